// File: doc/BRIEF.md
# Configurable Serial Frame Transmitter

This block takes characters from a small holding queue and shifts them out, one frame at a time, on a single serial line. Its timing comes from an oversampling tick supplied by an external baud generator. Each bit lasts a fixed number of those ticks. A set of line-control inputs chooses the character length, the number of stop bits, whether a parity bit is added and which kind, and whether the line is forced into a break. The block's only status outputs are two flags. One says the holding queue is empty. The other says the whole transmitter is empty.

Software or a bus front end pushes bytes into the queue through a valid/ready pair. The shifter pulls the oldest byte as soon as it is idle and both enables are set. The line-control inputs are captured when a character is pulled from the queue, so reconfiguring during a frame only affects later frames. Clearing either enable stops the frame that is being sent and returns the line to idle. Any characters still queued are kept and are sent once the enables return.

Top module: `uart_frame_tx`

## Requirements
- R1: The length code sets the number of data bits. Code 0 gives 5 data bits, 1 gives 6, 2 gives 7 and 3 gives 8. Only the low bits of the queued byte are sent.
- R2: A frame is one start bit at 0, then the data bits with the least significant bit first, then the parity bit if enabled, then the stop bits at 1. Between frames the line is 1.
- R3: With parity enabled, the parity bit is chosen by par_type. Code 0 makes the count of ones in data plus parity odd. Code 1 makes that count even. Code 2 sends a constant 1 and code 3 sends a constant 0. With parity disabled, no parity bit is sent.
- R4: With stop_sel clear there is one stop bit. With stop_sel set there are two stop bits, except at length code 0, where the stop time is one and a half bits.
- R5: Each bit lasts 16 oversampling ticks, or 8 ticks when over8 is set. A half stop bit lasts half that number.
- R6: While brk is 1, txd is 0, whatever else the block is doing.
- R7: A frame starts only when en_global and en_tx are both 1. If either is cleared, the frame in progress stops, txd returns to 1 (unless brk is set), and the queue contents are kept.
- R8: hold_empty is 1 exactly when the queue holds no character. tx_empty is 1 exactly when the queue is empty and no frame is in progress.
- R9: The queue holds DEPTH characters and sends them in arrival order. push_ready is 0 when the queue is full, and a push made while full is dropped.
- R10: The line-control inputs are captured when a character leaves the queue. Changing them during a frame does not alter that frame.
- R11: After reset, txd, hold_empty, tx_empty and push_ready are all 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_global | input | 1 | Block-wide enable |
| en_tx | input | 1 | Transmit enable |
| os_tick | input | 1 | Oversampling tick, one clock wide |
| over8 | input | 1 | 1 selects 8 ticks per bit, 0 selects 16 |
| len_code | input | 2 | Character length code |
| stop_sel | input | 1 | Stop-bit select |
| par_en | input | 1 | Parity bit enable |
| par_type | input | 2 | Parity kind code |
| brk | input | 1 | Force the line to 0 |
| push_valid | input | 1 | Push request into the queue |
| push_data | input | 8 | Character to queue |
| push_ready | output | 1 | Queue can accept a push |
| txd | output | 1 | Serial output |
| hold_empty | output | 1 | Queue is empty |
| tx_empty | output | 1 | Queue and shifter are both empty |

## Verification
Two things can land on the same clock edge. One is a push from the producer. The other is the shifter pulling a character, either from a queue that is already full or from one holding a single entry. The bench creates both cases by pushing continuously while frames end back to back, and by pushing at the exact cycle the line returns to idle. A reference model built on a queue compares push_ready, both empty flags and the line on every clock. A second coincidence, brk being raised or an enable being dropped in the middle of a stop or parity bit, is checked the same way against the model's expected line level.

// File: rtl/uft_pkg.sv
package uft_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_START = 3'd1,
        ST_DATA  = 3'd2,
        ST_PAR   = 3'd3,
        ST_STOP  = 3'd4
    } tx_state_e;

    typedef struct packed {
        logic       over8;
        logic [1:0] len;
        logic       stop2;
        logic       par_on;
        logic [1:0] par_kind;
    } line_cfg_t;

    localparam int CHAR_W   = 8;
    localparam int MIN_BITS = 5;

endpackage

// File: rtl/uft_queue.sv
module uft_queue #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic         ready,
    output logic         empty,
    output logic [W-1:0] head
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [PW-1:0] rd;
        logic [PW-1:0] wr;
        logic [CW-1:0] cnt;
    } q_regs_t;

    q_regs_t     r_d, r_q;
    logic [W-1:0] mem_q [DEPTH];
    logic [W-1:0] mem_d [DEPTH];
    logic         put, take;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    always_comb begin
        r_d   = r_q;
        mem_d = mem_q;
        ready = (r_q.cnt != CW'(DEPTH));
        empty = (r_q.cnt == '0);
        head  = mem_q[r_q.rd];
        put   = push && ready;
        take  = pop && !empty;
        if (put) begin
            mem_d[r_q.wr] = push_data;
            r_d.wr        = bump(r_q.wr);
        end
        if (take) begin
            r_d.rd = bump(r_q.rd);
        end
        case ({put, take})
            2'b10:   r_d.cnt = r_q.cnt + CW'(1);
            2'b01:   r_d.cnt = r_q.cnt - CW'(1);
            default: r_d.cnt = r_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_ff @(posedge clk) begin
        mem_q <= mem_d;
    end

    p_count_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.cnt <= CW'(DEPTH));

    p_no_underflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);

    p_full_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready && !pop) |=> !ready);

endmodule

// File: rtl/uft_parity.sv
module uft_parity
    import uft_pkg::*;
(
    input  logic [CHAR_W-1:0] data,
    input  line_cfg_t         cfg,
    output logic              pbit
);
    logic [CHAR_W-1:0] mask;
    logic              ones_odd;

    always_comb begin
        for (int i = 0; i < CHAR_W; i++) begin
            mask[i] = (i < (MIN_BITS + int'(cfg.len)));
        end
        ones_odd = ^(data & mask);
        case (cfg.par_kind)
            2'd0:    pbit = ~ones_odd;
            2'd1:    pbit = ones_odd;
            2'd2:    pbit = 1'b1;
            default: pbit = 1'b0;
        endcase
    end

endmodule

// File: rtl/uft_shifter.sv
module uft_shifter
    import uft_pkg::*;
#(
    parameter int TICKS_X16 = 16,
    parameter int TICKS_X8  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              os_tick,
    input  logic              brk,
    input  line_cfg_t         cfg_in,
    input  logic              q_empty,
    input  logic [CHAR_W-1:0] q_data,
    output logic              pop,
    output logic              idle,
    output logic              txd
);
    localparam int TW = $clog2(2 * TICKS_X16 + 1);

    typedef struct packed {
        tx_state_e         st;
        logic [TW-1:0]     ticks;
        logic [2:0]        bidx;
        logic [CHAR_W-1:0] sh;
        logic              pbit;
        line_cfg_t         cfg;
    } sh_regs_t;

    sh_regs_t      r_d, r_q;
    logic          new_pbit;
    logic [TW-1:0] bit_len, stop_len, limit;
    logic [2:0]    last_idx;
    logic          last_tick;

    uft_parity u_par (
        .data (q_data),
        .cfg  (cfg_in),
        .pbit (new_pbit)
    );

    always_comb begin
        r_d = r_q;
        pop = 1'b0;
        bit_len = r_q.cfg.over8 ? TW'(TICKS_X8) : TW'(TICKS_X16);
        if (!r_q.cfg.stop2) begin
            stop_len = bit_len;
        end else if (r_q.cfg.len == 2'd0) begin
            stop_len = bit_len + (bit_len >> 1);
        end else begin
            stop_len = bit_len << 1;
        end
        limit     = (r_q.st == ST_STOP) ? stop_len : bit_len;
        last_tick = os_tick && (r_q.ticks == limit - TW'(1));
        last_idx  = {1'b0, r_q.cfg.len} + 3'd4;

        if (!run) begin
            r_d.st    = ST_IDLE;
            r_d.ticks = '0;
        end else if (r_q.st == ST_IDLE) begin
            if (!q_empty) begin
                pop       = 1'b1;
                r_d.st    = ST_START;
                r_d.ticks = '0;
                r_d.bidx  = '0;
                r_d.sh    = q_data;
                r_d.pbit  = new_pbit;
                r_d.cfg   = cfg_in;
            end
        end else if (os_tick) begin
            if (last_tick) begin
                r_d.ticks = '0;
                case (r_q.st)
                    ST_START: r_d.st = ST_DATA;
                    ST_DATA: begin
                        r_d.sh = r_q.sh >> 1;
                        if (r_q.bidx == last_idx) begin
                            r_d.st = r_q.cfg.par_on ? ST_PAR : ST_STOP;
                        end else begin
                            r_d.bidx = r_q.bidx + 3'd1;
                        end
                    end
                    ST_PAR:  r_d.st = ST_STOP;
                    default: r_d.st = ST_IDLE;
                endcase
            end else begin
                r_d.ticks = r_q.ticks + TW'(1);
            end
        end

        idle = (r_q.st == ST_IDLE);
        if (brk) begin
            txd = 1'b0;
        end else if (!run) begin
            txd = 1'b1;
        end else begin
            case (r_q.st)
                ST_START: txd = 1'b0;
                ST_DATA:  txd = r_q.sh[0];
                ST_PAR:   txd = r_q.pbit;
                default:  txd = 1'b1;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    p_bit_index_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_DATA) |-> (r_q.bidx <= last_idx));

    p_start_from_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_START && $past(r_q.st) != ST_START) |-> $past(r_q.st) == ST_IDLE);

    p_tick_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st != ST_IDLE) |-> (r_q.ticks < limit));

    p_abort_to_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (r_q.st == ST_IDLE));

    p_cfg_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st != ST_IDLE && $past(r_q.st) != ST_IDLE) |-> $stable(r_q.cfg));

endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx
    import uft_pkg::*;
#(
    parameter int DEPTH     = 4,
    parameter int TICKS_X16 = 16,
    parameter int TICKS_X8  = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en_global,
    input  logic       en_tx,
    input  logic       os_tick,
    input  logic       over8,
    input  logic [1:0] len_code,
    input  logic       stop_sel,
    input  logic       par_en,
    input  logic [1:0] par_type,
    input  logic       brk,
    input  logic       push_valid,
    input  logic [7:0] push_data,
    output logic       push_ready,
    output logic       txd,
    output logic       hold_empty,
    output logic       tx_empty
);
    line_cfg_t         cfg;
    logic              run, q_empty, pop, sh_idle;
    logic [CHAR_W-1:0] q_head;

    always_comb begin
        run = en_global && en_tx;
        cfg = '{over8: over8, len: len_code, stop2: stop_sel,
                par_on: par_en, par_kind: par_type};
        hold_empty = q_empty;
        tx_empty   = q_empty && sh_idle;
    end

    uft_queue #(.W(CHAR_W), .DEPTH(DEPTH)) u_queue (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push_valid),
        .push_data (push_data),
        .pop       (pop),
        .ready     (push_ready),
        .empty     (q_empty),
        .head      (q_head)
    );

    uft_shifter #(.TICKS_X16(TICKS_X16), .TICKS_X8(TICKS_X8)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .os_tick (os_tick),
        .brk     (brk),
        .cfg_in  (cfg),
        .q_empty (q_empty),
        .q_data  (q_head),
        .pop     (pop),
        .idle    (sh_idle),
        .txd     (txd)
    );

    p_busy_needs_run_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !brk) |-> txd);

    p_break_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        brk |-> !txd);

    p_empty_order_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tx_empty |-> hold_empty);

endmodule

// File: tb/tb_uart_frame_tx.sv
module tb_uart_frame_tx;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 4;
    localparam int TDIV       = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en_global = 1'b0, en_tx = 1'b0, os_tick = 1'b0, over8 = 1'b0;
    logic [1:0] len_code = 2'd3, par_type = 2'd0;
    logic       stop_sel = 1'b0, par_en = 1'b0, brk = 1'b0, push_valid = 1'b0;
    logic [7:0] push_data = 8'h00;
    logic       push_ready, txd, hold_empty, tx_empty;

    int    n_chk = 0, n_bad = 0, cyc = 0;
    string cur_req = "R11";

    uart_frame_tx #(.DEPTH(DEPTH)) dut (
        .clk(clk), .rst_n(rst_n), .en_global(en_global), .en_tx(en_tx),
        .os_tick(os_tick), .over8(over8), .len_code(len_code),
        .stop_sel(stop_sel), .par_en(par_en), .par_type(par_type), .brk(brk),
        .push_valid(push_valid), .push_data(push_data), .push_ready(push_ready),
        .txd(txd), .hold_empty(hold_empty), .tx_empty(tx_empty)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Reference model: phase 0 idle, 1 start, 2 data, 3 parity, 4 stop
    byte unsigned mq[$];
    int  ph = 0, tk = 0, nb = 8, bl = 16, sl = 16, bi = 0;
    bit  pe = 0, pb = 0;
    bit [7:0] cur = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            mq.delete(); ph = 0; tk = 0;
        end else begin
            automatic bit run = en_global && en_tx;
            automatic int sz = mq.size();
            automatic bit do_pop = 0;
            if (!run) begin
                ph = 0; tk = 0;
            end else if (ph == 0) begin
                if (sz > 0) begin
                    automatic int ones = 0;
                    do_pop = 1;
                    cur = mq[0];
                    nb  = 5 + int'(len_code);
                    bl  = over8 ? 8 : 16;
                    sl  = !stop_sel ? bl : (nb == 5 ? (bl * 3) / 2 : 2 * bl);
                    pe  = par_en;
                    for (int i = 0; i < nb; i++) ones += cur[i];
                    case (par_type)
                        2'd0: pb = (ones % 2 == 0);
                        2'd1: pb = (ones % 2 == 1);
                        2'd2: pb = 1;
                        default: pb = 0;
                    endcase
                    bi = 0; ph = 1; tk = 0;
                end
            end else if (os_tick) begin
                tk++;
                if (tk == ((ph == 4) ? sl : bl)) begin
                    tk = 0;
                    case (ph)
                        1: begin ph = 2; bi = 0; end
                        2: if (bi == nb - 1) ph = pe ? 3 : 4; else bi++;
                        3: ph = 4;
                        default: ph = 0;
                    endcase
                end
            end
            if (push_valid && sz < DEPTH) mq.push_back(push_data);
            if (do_pop) void'(mq.pop_front());
        end
    end

    task automatic chk(input string req, input string what, input logic got, input logic exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s at cycle %0d: got=%b exp=%b", req, what, cyc, got, exp);
        end
    endtask

    task automatic compare();
        automatic logic e_txd;
        if (brk) e_txd = 0;
        else if (!(en_global && en_tx)) e_txd = 1;
        else case (ph)
            1: e_txd = 0;
            2: e_txd = cur[bi];
            3: e_txd = pb;
            default: e_txd = 1;
        endcase
        chk(brk ? "R6" : cur_req, "txd", txd, e_txd);
        chk("R8", "hold_empty", hold_empty, mq.size() == 0);
        chk("R8", "tx_empty", tx_empty, mq.size() == 0 && ph == 0);
        chk("R9", "push_ready", push_ready, mq.size() < DEPTH);
    endtask

    task automatic step();
        @(negedge clk);
        compare();
        cyc++;
        os_tick = (cyc % TDIV == 0);
    endtask

    task automatic send(input byte unsigned b);
        push_valid = 1; push_data = b;
        step();
        push_valid = 0;
    endtask

    task automatic drain();
        for (int i = 0; i < 5000 && !(mq.size() == 0 && ph == 0); i++) step();
        step(); step();
    endtask

    task automatic cfgset(input bit o8, input bit [1:0] ln, input bit st,
                          input bit p, input bit [1:0] pt);
        over8 = o8; len_code = ln; stop_sel = st; par_en = p; par_type = pt;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired at cycle %0d: got=running exp=finished", cyc);
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset state
        chk("R11", "txd", txd, 1'b1);
        chk("R11", "hold_empty", hold_empty, 1'b1);
        chk("R11", "tx_empty", tx_empty, 1'b1);
        chk("R11", "push_ready", push_ready, 1'b1);
        rst_n = 1;
        step();
        en_global = 1; en_tx = 1;

        // R2: basic 8N1 frame
        cur_req = "R2"; cfgset(0, 3, 0, 0, 0);
        send(8'hA5); drain();

        // R1: each length code
        cur_req = "R1";
        for (int l = 0; l < 4; l++) begin
            cfgset(0, 2'(l), 0, 0, 0); send(8'hF3 ^ 8'(l * 37)); drain();
        end

        // R3: parity kinds at two lengths
        cur_req = "R3";
        for (int k = 0; k < 4; k++) begin
            cfgset(0, 3, 0, 1, 2'(k)); send(8'h6B); drain();
            cfgset(1, 2, 0, 1, 2'(k)); send(8'hD4); drain();
        end

        // R4: stop-bit variants, R5: 8x mode and half stop bit
        cur_req = "R4";
        cfgset(0, 3, 1, 0, 0); send(8'h81); drain();
        cfgset(0, 0, 1, 1, 1); send(8'h1F); drain();
        cfgset(0, 1, 1, 0, 0); send(8'h2A); drain();
        cur_req = "R5";
        cfgset(1, 0, 1, 0, 0); send(8'h15); drain();
        cfgset(1, 3, 0, 1, 0); send(8'hC3); drain();

        // R6: break while idle and in the middle of a frame
        cur_req = "R2";
        brk = 1; repeat (20) step(); brk = 0;
        cfgset(0, 3, 0, 1, 1); send(8'h5A);
        repeat (150) step(); brk = 1; repeat (60) step(); brk = 0; drain();
        chk("R6", "txd after break", txd, 1'b1);

        // R9: fill while disabled, extra push dropped, order kept
        cur_req = "R9";
        en_tx = 0; cfgset(0, 3, 0, 0, 0);
        for (int i = 0; i < DEPTH + 1; i++) send(8'h10 + 8'(i));
        step();
        chk("R9", "push_ready when full", push_ready, 1'b0);
        chk("R7", "txd idle while disabled", txd, 1'b1);
        en_tx = 1;
        // push continuously as frames complete back to back
        for (int i = 0; i < 2000; i++) begin
            push_valid = (i % 97 == 0); push_data = 8'(i);
            step();
        end
        push_valid = 0; drain();

        // R7: abort mid-frame, queue kept
        cur_req = "R7";
        send(8'hE7); send(8'h3C);
        repeat (120) step();
        en_global = 0; repeat (10) step();
        chk("R7", "hold_empty after abort", hold_empty, 1'b0);
        chk("R7", "txd after abort", txd, 1'b1);
        en_global = 1; drain();

        // R10: change line control during a frame
        cur_req = "R10";
        cfgset(0, 3, 1, 1, 0); send(8'h99);
        repeat (100) step();
        cfgset(1, 0, 0, 0, 2); send(8'h66);
        repeat (150) step();
        cfgset(0, 1, 1, 1, 3);
        drain();

        // push at the cycle the line goes idle
        cur_req = "R2";
        cfgset(1, 0, 0, 0, 0); send(8'h0B);
        for (int i = 0; i < 3000 && ph != 0; i++) step();
        send(8'h14); drain();
        chk("R8", "tx_empty at end", tx_empty, 1'b1);

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule